// File: doc/BRIEF.md
# Watchdog Timer with Paired Clear

This block guards a small processor core against runaway software. It counts enable ticks from one of two sources picked by a strap: a free-running low-speed oscillator tick, or an instruction-rate tick made inside the block by dividing the system clock by four. Every tick advances a fixed 256-step base counter. Each wrap of that counter advances a prescaler whose terminal count is set by a 3-bit ratio code. When the prescaler reaches its terminal count, the block requests a reset.

The core keeps the count from expiring with clear strobes. A strap picks one of two clear schemes. In the first, one clear strobe is enough. In the second, two distinct half-clear strobes must both arrive, in either order, before the count restarts. A halt strobe also restarts the count and marks the power-down status.

What an expiry does depends on the core's power-down flag. While the core runs, it requests a full chip reset and raises the time-out flag. While the core is powered down, it requests only a warm reset, which restarts the program counter and the stack pointer. A third strap turns the whole block off.

Top module: `wdog_guard`

## Requirements
- R1: After `rst_n` is released, `chip_rst_req`, `warm_rst_req`, `to_flag` and `pdf_flag` are all 0.
- R2: With `cfg_src_osc`=1, each cycle with `osc_tick` high is one count. Expiry happens on the 256·2^N-th count after a clear, where N is the registered ratio code (000 gives 1:1 and 111 gives 1:128). The request rises in the cycle after that count and lasts exactly one cycle.
- R3: With `cfg_src_osc`=0, one count occurs every fourth clock. Every clear event restarts this four-clock phase. While `pd_i` is high, counting and the phase both hold.
- R4: An expiry while `pd_i`=1 pulses `warm_rst_req` and leaves `to_flag` unchanged.
- R5: An expiry while `pd_i`=0 pulses `chip_rst_req` and sets `to_flag`. An expiry also restarts the count from zero.
- R6: With `cfg_pair`=0, `clr_single` restarts the base counter and the prescaler. `clr_half1` and `clr_half2` have no effect in this mode.
- R7: With `cfg_pair`=1, the count restarts only once both `clr_half1` and `clr_half2` have been seen. They may come in either order or in the same cycle. A lone half does not restart the count, and `clr_single` has no effect. A remembered half is dropped whenever the count restarts, whether by clear, halt or expiry.
- R8: `halt_stb` restarts the count, sets `pdf_flag` and clears `to_flag`.
- R9: With `cfg_en`=0, the block never requests a reset, and strobes leave both flags unchanged.
- R10: `sel_din` is captured into the ratio register when `sel_wr` is high. A new ratio does not restart the count. Expiry occurs at the first base-counter wrap at which the prescaler count is at or above 2^N−1 for the new N.
- R11: `chip_rst_req` and `warm_rst_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low external reset |
| cfg_en | input | 1 | Strap: 1 enables the watchdog |
| cfg_src_osc | input | 1 | Strap: 1 selects the oscillator tick, 0 selects the instruction tick |
| cfg_pair | input | 1 | Strap: 1 selects paired half-clears |
| osc_tick | input | 1 | One-cycle tick from the low-speed oscillator |
| pd_i | input | 1 | Core is in power-down |
| sel_wr | input | 1 | Write strobe for the ratio code |
| sel_din | input | 3 | Ratio code N, for a ratio of 1:2^N |
| clr_single | input | 1 | Single-instruction clear strobe |
| clr_half1 | input | 1 | First half of the paired clear |
| clr_half2 | input | 1 | Second half of the paired clear |
| halt_stb | input | 1 | Halt instruction strobe |
| chip_rst_req | output | 1 | One-cycle chip reset request |
| warm_rst_req | output | 1 | One-cycle warm reset request |
| to_flag | output | 1 | Time-out status |
| pdf_flag | output | 1 | Power-down status |

## Verification
The properties assume the three straps stay constant between resets and that every strobe is high for one cycle at a time. They also assume `halt_stb` alone decides the flag changes in the cycle it is high. The stimulus changes straps only while `rst_n` is low, and it drives each strobe for one cycle with `osc_tick` low. Each ratio case starts from an explicit clear, so the expected expiry cycle is simply 256·2^N counts, or four times that many clocks for the instruction tick.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   typedef enum logic [1:0] {
      WD_REQ_NONE = 2'd0,
      WD_REQ_CHIP = 2'd1,
      WD_REQ_WARM = 2'd2
   } wd_req_e;

   // Pick the kind of reset an expiry asks for, from the core's power state
   function automatic wd_req_e wd_classify(input logic expired, input logic powered_down);
      if (!expired)          return WD_REQ_NONE;
      else if (powered_down) return WD_REQ_WARM;
      else                   return WD_REQ_CHIP;
   endfunction

endpackage

// File: rtl/wdog_tick_src.sv
module wdog_tick_src #(
   parameter int unsigned INSTR_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic use_osc,
   input  logic osc_tick,
   input  logic pd_i,
   input  logic phase_clr,
   output logic cnt_tick
);
   localparam int unsigned PH_W = (INSTR_DIV > 1) ? $clog2(INSTR_DIV) : 1;

   logic instr_tick;

   if (INSTR_DIV == 1) begin : g_nodiv
      // Instruction rate equals the system clock; only power-down stops it
      assign instr_tick = !pd_i;
   end else begin : g_div
      logic [PH_W-1:0] ph_q;
      localparam logic [PH_W-1:0] PH_LAST = PH_W'(INSTR_DIV - 1);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ph_q <= '0;
         end else if (phase_clr || !en) begin
            ph_q <= '0;
         end else if (!pd_i) begin
            if (ph_q == PH_LAST) ph_q <= '0;
            else                 ph_q <= ph_q + 1'b1;
         end
      end

      assign instr_tick = !pd_i && (ph_q == PH_LAST);
   end

   // A clear in the same cycle wins over a count
   assign cnt_tick = en && !phase_clr && (use_osc ? osc_tick : instr_tick);

endmodule

// File: rtl/wdog_chain.sv
module wdog_chain #(
   parameter int unsigned BASE_W = 8,
   parameter int unsigned SEL_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic             clr,
   input  logic [SEL_W-1:0] sel,
   output logic             expire
);
   localparam int unsigned PRE_W = (1 << SEL_W) - 1;

   logic [BASE_W-1:0] base_q;
   logic [PRE_W-1:0]  pre_q;
   logic [PRE_W:0]    one_sh;
   logic [PRE_W:0]    lim_w;
   logic              wrap;

   always_comb begin
      one_sh = {{PRE_W{1'b0}}, 1'b1} << sel;
      lim_w  = one_sh - {{PRE_W{1'b0}}, 1'b1};
   end

   assign wrap   = tick && (&base_q);
   // "At or above" so that lowering the ratio mid-count still ends the count
   assign expire = wrap && (pre_q >= lim_w[PRE_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         pre_q  <= '0;
      end else if (clr || !en) begin
         base_q <= '0;
         pre_q  <= '0;
      end else if (tick) begin
         base_q <= base_q + 1'b1;
         if (wrap) begin
            if (expire) pre_q <= '0;
            else        pre_q <= pre_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/wdog_clear_ctl.sv
module wdog_clear_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic pair_mode,
   input  logic clr_single,
   input  logic clr_half1,
   input  logic clr_half2,
   input  logic halt_stb,
   input  logic expire,
   output logic clr_o
);
   logic h1_q, h2_q;
   logic h1_n, h2_n;
   logic pair_done;

   assign h1_n      = h1_q | clr_half1;
   assign h2_n      = h2_q | clr_half2;
   assign pair_done = pair_mode && h1_n && h2_n;
   assign clr_o     = en && (halt_stb || (!pair_mode && clr_single) || pair_done);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h1_q <= 1'b0;
         h2_q <= 1'b0;
      end else if (!en || !pair_mode || clr_o || expire) begin
         h1_q <= 1'b0;
         h2_q <= 1'b0;
      end else begin
         h1_q <= h1_n;
         h2_q <= h2_n;
      end
   end

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
   import wdog_pkg::*;
#(
   parameter int unsigned BASE_W    = 8,
   parameter int unsigned SEL_W     = 3,
   parameter int unsigned INSTR_DIV = 4,
   parameter logic [SEL_W-1:0] SEL_RESET = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_en,
   input  logic             cfg_src_osc,
   input  logic             cfg_pair,
   input  logic             osc_tick,
   input  logic             pd_i,
   input  logic             sel_wr,
   input  logic [SEL_W-1:0] sel_din,
   input  logic             clr_single,
   input  logic             clr_half1,
   input  logic             clr_half2,
   input  logic             halt_stb,
   output logic             chip_rst_req,
   output logic             warm_rst_req,
   output logic             to_flag,
   output logic             pdf_flag
);
   if (BASE_W < 1) begin : g_bad_base
      $error("wdog_guard: BASE_W must be at least 1");
   end
   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("wdog_guard: SEL_W must be 1 to 4");
   end
   if (INSTR_DIV < 1) begin : g_bad_div
      $error("wdog_guard: INSTR_DIV must be at least 1");
   end

   logic [SEL_W-1:0] sel_q;
   logic             cnt_tick;
   logic             clr_ev;
   logic             expire;
   wd_req_e          req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sel_q <= SEL_RESET;
      else if (sel_wr) sel_q <= sel_din;
   end

   wdog_clear_ctl u_clr (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (cfg_en),
      .pair_mode  (cfg_pair),
      .clr_single (clr_single),
      .clr_half1  (clr_half1),
      .clr_half2  (clr_half2),
      .halt_stb   (halt_stb),
      .expire     (expire),
      .clr_o      (clr_ev)
   );

   wdog_tick_src #(.INSTR_DIV(INSTR_DIV)) u_tick (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (cfg_en),
      .use_osc   (cfg_src_osc),
      .osc_tick  (osc_tick),
      .pd_i      (pd_i),
      .phase_clr (clr_ev),
      .cnt_tick  (cnt_tick)
   );

   wdog_chain #(.BASE_W(BASE_W), .SEL_W(SEL_W)) u_chain (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (cfg_en),
      .tick   (cnt_tick),
      .clr    (clr_ev),
      .sel    (sel_q),
      .expire (expire)
   );

   assign req = wd_classify(expire, pd_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chip_rst_req <= 1'b0;
         warm_rst_req <= 1'b0;
         to_flag      <= 1'b0;
         pdf_flag     <= 1'b0;
      end else begin
         chip_rst_req <= (req == WD_REQ_CHIP);
         warm_rst_req <= (req == WD_REQ_WARM);
         if (cfg_en) begin
            if (halt_stb) begin
               pdf_flag <= 1'b1;
               to_flag  <= 1'b0;
            end else if (req == WD_REQ_CHIP) begin
               to_flag  <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_en,
   input logic halt_stb,
   input logic chip_rst_req,
   input logic warm_rst_req,
   input logic to_flag,
   input logic pdf_flag
);
   AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(chip_rst_req && warm_rst_req)); // R11

   AST_CHIP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      chip_rst_req |=> !chip_rst_req); // R2

   AST_WARM_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      warm_rst_req |=> !warm_rst_req); // R4

   AST_CHIP_MARKS_TO: assert property (@(posedge clk) disable iff (!rst_n)
      chip_rst_req |-> to_flag); // R5

   AST_HALT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en && halt_stb) |=> (pdf_flag && !to_flag)); // R8

   AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> (!chip_rst_req && !warm_rst_req)); // R9

   AST_OFF_PDF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en && $past(!cfg_en)) |-> $stable(pdf_flag)); // R9

endmodule

bind wdog_guard wdog_guard_chk chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_en       (cfg_en),
   .halt_stb     (halt_stb),
   .chip_rst_req (chip_rst_req),
   .warm_rst_req (warm_rst_req),
   .to_flag      (to_flag),
   .pdf_flag     (pdf_flag)
);

// File: tb/wdog_guard_tb_top.sv
`timescale 1ns/1ps
module wdog_guard_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_en = 1'b1, cfg_src_osc = 1'b1, cfg_pair = 1'b0;
   logic osc_tick = 1'b0, pd_i = 1'b0, sel_wr = 1'b0;
   logic [2:0] sel_din = 3'd0;
   logic clr_single = 1'b0, clr_half1 = 1'b0, clr_half2 = 1'b0, halt_stb = 1'b0;
   logic chip_rst_req, warm_rst_req, to_flag, pdf_flag;

   int checks = 0;
   int fails  = 0;
   bit saw_req;

   always #2.5 clk = ~clk;

   wdog_guard dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_src_osc(cfg_src_osc),
      .cfg_pair(cfg_pair), .osc_tick(osc_tick), .pd_i(pd_i), .sel_wr(sel_wr),
      .sel_din(sel_din), .clr_single(clr_single), .clr_half1(clr_half1),
      .clr_half2(clr_half2), .halt_stb(halt_stb), .chip_rst_req(chip_rst_req),
      .warm_rst_req(warm_rst_req), .to_flag(to_flag), .pdf_flag(pdf_flag)
   );

   typedef struct packed {
      logic        src_osc;
      logic        pair;
      logic [2:0]  sel;
      logic        pd;
      logic [16:0] clocks;
      logic        warm;
   } vec_t;

   localparam vec_t VECS [5] = '{
      '{src_osc:1'b1, pair:1'b0, sel:3'd0, pd:1'b0, clocks:17'd256,  warm:1'b0},
      '{src_osc:1'b1, pair:1'b1, sel:3'd3, pd:1'b0, clocks:17'd2048, warm:1'b0},
      '{src_osc:1'b1, pair:1'b0, sel:3'd1, pd:1'b1, clocks:17'd512,  warm:1'b1},
      '{src_osc:1'b0, pair:1'b0, sel:3'd0, pd:1'b0, clocks:17'd1024, warm:1'b0},
      '{src_osc:1'b0, pair:1'b1, sel:3'd2, pd:1'b0, clocks:17'd4096, warm:1'b0}
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      if (chip_rst_req || warm_rst_req) saw_req = 1'b1;
   endtask

   task automatic run(input int n, input logic tk);
      saw_req = 1'b0;
      for (int i = 0; i < n; i++) begin
         osc_tick = tk;
         step();
      end
      osc_tick = 1'b0;
   endtask

   task automatic do_reset(input logic en, input logic osc, input logic pair);
      @(negedge clk);
      rst_n = 1'b0; cfg_en = en; cfg_src_osc = osc; cfg_pair = pair; pd_i = 1'b0;
      step(); step();
      rst_n = 1'b1;
   endtask

   task automatic strobe(input logic s, input logic h1, input logic h2, input logic ht);
      clr_single = s; clr_half1 = h1; clr_half2 = h2; halt_stb = ht;
      step();
      clr_single = 1'b0; clr_half1 = 1'b0; clr_half2 = 1'b0; halt_stb = 1'b0;
   endtask

   task automatic write_sel(input logic [2:0] v);
      sel_wr = 1'b1; sel_din = v;
      step();
      sel_wr = 1'b0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #1000000;
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      summary();
   end

   initial begin
      // R1: reset state
      do_reset(1'b1, 1'b1, 1'b0);
      chk("R1 chip", chip_rst_req, 0);
      chk("R1 warm", warm_rst_req, 0);
      chk("R1 to",   to_flag, 0);
      chk("R1 pdf",  pdf_flag, 0);

      // R2 R3 R4 R5: ratio and source table
      foreach (VECS[k]) begin
         do_reset(1'b1, VECS[k].src_osc, VECS[k].pair);
         write_sel(VECS[k].sel);
         if (VECS[k].pair) strobe(1'b0, 1'b1, 1'b1, 1'b0);
         else              strobe(1'b1, 1'b0, 1'b0, 1'b0);
         pd_i = VECS[k].pd;
         run(int'(VECS[k].clocks) - 1, VECS[k].src_osc);
         chk("R2 R3 no early expiry", saw_req, 0);
         run(1, VECS[k].src_osc);
         chk("R2 R3 R5 chip pulse", chip_rst_req, int'(!VECS[k].warm));
         chk("R4 warm pulse", warm_rst_req, int'(VECS[k].warm));
         chk("R4 R5 to flag", to_flag, int'(!VECS[k].warm));
         pd_i = 1'b0;
         step();
         chk("R2 pulse one cycle", chip_rst_req | warm_rst_req, 0);
      end

      // R6: single mode
      do_reset(1'b1, 1'b1, 1'b0);
      write_sel(3'd0);
      strobe(1'b1, 1'b0, 1'b0, 1'b0);
      run(200, 1'b1);
      strobe(1'b0, 1'b1, 1'b1, 1'b0);
      run(55, 1'b1);
      chk("R6 halves ignored, no early", saw_req, 0);
      run(1, 1'b1);
      chk("R6 halves ignored, expiry", chip_rst_req, 1);
      run(200, 1'b1);
      strobe(1'b1, 1'b0, 1'b0, 1'b0);
      run(255, 1'b1);
      chk("R6 single clear restarts", saw_req, 0);
      run(1, 1'b1);
      chk("R6 expiry after clear", chip_rst_req, 1);

      // R8: halt
      strobe(1'b0, 1'b0, 1'b0, 1'b1);
      chk("R8 pdf set", pdf_flag, 1);
      chk("R8 to cleared", to_flag, 0);
      run(255, 1'b1);
      chk("R8 halt restarts count", saw_req, 0);
      run(1, 1'b1);
      chk("R8 expiry after halt", chip_rst_req, 1);

      // R7: paired mode
      do_reset(1'b1, 1'b1, 1'b1);
      write_sel(3'd0);
      strobe(1'b0, 1'b1, 1'b1, 1'b0);
      run(200, 1'b1);
      strobe(1'b1, 1'b0, 1'b0, 1'b0);
      run(56, 1'b1);
      chk("R7 single ignored", chip_rst_req, 1);
      run(200, 1'b1);
      strobe(1'b0, 1'b1, 1'b0, 1'b0);
      run(56, 1'b1);
      chk("R7 lone half1", chip_rst_req, 1);
      run(200, 1'b1);
      strobe(1'b0, 1'b0, 1'b1, 1'b0);
      run(56, 1'b1);
      chk("R7 half1 dropped by expiry", chip_rst_req, 1);
      run(100, 1'b1);
      strobe(1'b0, 1'b0, 1'b1, 1'b0);
      run(50, 1'b1);
      strobe(1'b0, 1'b1, 1'b0, 1'b0);
      run(255, 1'b1);
      chk("R7 half2 then half1 clears", saw_req, 0);
      run(1, 1'b1);
      chk("R7 expiry after pair", chip_rst_req, 1);
      run(100, 1'b1);
      strobe(1'b0, 1'b1, 1'b0, 1'b0);
      strobe(1'b0, 1'b0, 1'b0, 1'b1);
      run(100, 1'b1);
      strobe(1'b0, 1'b0, 1'b1, 1'b0);
      run(155, 1'b1);
      chk("R7 halt drops half", saw_req, 0);
      run(1, 1'b1);
      chk("R7 lone half2 after halt", chip_rst_req, 1);

      // R10: ratio change keeps count
      do_reset(1'b1, 1'b1, 1'b0);
      write_sel(3'd2);
      strobe(1'b1, 1'b0, 1'b0, 1'b0);
      run(512, 1'b1);
      chk("R10 no expiry at 1:4 yet", saw_req, 0);
      write_sel(3'd1);
      run(255, 1'b1);
      chk("R10 not before next wrap", saw_req, 0);
      run(1, 1'b1);
      chk("R10 expiry at next wrap", chip_rst_req, 1);

      // R3: instruction source holds in power-down
      do_reset(1'b1, 1'b0, 1'b0);
      write_sel(3'd0);
      strobe(1'b1, 1'b0, 1'b0, 1'b0);
      run(1000, 1'b0);
      pd_i = 1'b1;
      run(5000, 1'b0);
      chk("R3 frozen in power-down", saw_req, 0);
      pd_i = 1'b0;
      run(23, 1'b0);
      chk("R3 resume no early", saw_req, 0);
      run(1, 1'b0);
      chk("R3 resume expiry", chip_rst_req, 1);

      // R9: disabled
      do_reset(1'b0, 1'b1, 1'b0);
      write_sel(3'd0);
      run(600, 1'b1);
      chk("R9 no request", saw_req, 0);
      strobe(1'b0, 1'b0, 1'b0, 1'b1);
      chk("R9 pdf unchanged", pdf_flag, 0);
      chk("R9 to unchanged", to_flag, 0);

      summary();
   end
endmodule